// File: doc/BRIEF.md
# Wake-Event Power State Controller

This block is the top-level power-mode state machine of a power-management chip. It watches a push-button line and an AC-detect line, both active low. It also watches a power-enable level, a main-supply-present flag and two fault flags, one for undervoltage and one for overtemperature. From these it decides when the supply rails are to be brought up or taken down. It does not switch rails itself. It sends a one-cycle start-up or shut-down command to a separate rail sequencer.

The wake events that count depend on the current mode. In the two off modes, power-enable acts on its rising edge. In suspend, power-enable acts on its level. The push-button and AC-detect lines always act on their falling edges. In the full-off mode only, main supply present together with a low AC-detect line is also a wake. After a wake, the controller waits in a holding mode for power-enable. A grace window, counted in ticks of a slow timebase, limits that wait. Once power-enable arrives, only power-enable and the fault flags matter. All inputs are assumed to be synchronized to the clock already.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted, `mode` reads 1 (pre-off) and both sequencer commands are low. The mode encoding is: off=0, pre-off=1, suspend=2, waiting-for-enable=3, active=4.
- R2: In off, each of the following moves `mode` to 3 and pulses `seq_start` on the next clock edge: a falling edge on `btn_n`, a falling edge on `acdet_n`, a rising edge on `pwr_en`, or `supply_ok` high while `acdet_n` is low. A `pwr_en` that is already high and has no rising edge does not wake the controller.
- R3: In pre-off, a falling edge on `btn_n` or `acdet_n`, or a rising edge on `pwr_en`, wakes the controller. Here, `supply_ok` with `acdet_n` held low is no wake.
- R4: In suspend, a high `pwr_en` level wakes the controller, and so does a falling edge on `btn_n` or `acdet_n`.
- R5: While `uv_fault` or `ot_fault` is high, no wake is accepted in off, pre-off or suspend. An edge that falls inside a fault is lost: it does not take effect once the fault clears.
- R6: In mode 3 with `pwr_en` low, the controller stays in mode 3 as long as `btn_n` or `acdet_n` is low. This holds even after the grace window has run out.
- R7: Once `LIMIT_TICKS` ticks have been counted since entry to mode 3, with `btn_n` and `acdet_n` both high and `pwr_en` low, the controller pulses `seq_stop` and moves to off.
- R8: In mode 3, a high `pwr_en` moves the controller to active with no command pulse. This takes priority over an expired grace window in the same cycle.
- R9: In active, `acdet_n` and `btn_n` have no effect. A low `pwr_en` pulses `seq_stop` and moves the controller to suspend.
- R10: A fault in suspend, mode 3 or active pulses `seq_stop` and moves the controller to off on the next edge. The fault takes priority over a wake or a `pwr_en` drop in the same cycle.
- R11: `seq_start` and `seq_stop` are never high together, and each lasts exactly one cycle per transition.
- R12: Ticks outside mode 3 are not counted, and the grace count restarts from zero on each entry to mode 3. Without ticks, the window never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Slow timebase pulse, one cycle wide |
| btn_n | input | 1 | Push-button, low when pressed |
| acdet_n | input | 1 | AC-detect line, active low |
| pwr_en | input | 1 | Power-enable request from the host |
| supply_ok | input | 1 | Main supply present |
| uv_fault | input | 1 | Undervoltage lockout active |
| ot_fault | input | 1 | Overtemperature shutdown active |
| seq_start | output | 1 | One-cycle start-up command to the rail sequencer |
| seq_stop | output | 1 | One-cycle shut-down command to the rail sequencer |
| mode | output | 3 | Current mode (encoding as in R1) |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a fault and the drop of `pwr_en` in active. The bench provokes it by raising `ot_fault` and lowering `pwr_en` on the same cycle. It expects off rather than suspend, together with a single `seq_stop`. The second pair is the end of the grace window and the arrival of `pwr_en`. The bench holds the button until the window has run out, then releases the button and raises `pwr_en` in one cycle. It expects active and no stop pulse.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_OFF     = 3'd0,
    PM_PRE_OFF = 3'd1,
    PM_SUSPEND = 3'd2,
    PM_WAIT    = 3'd3,
    PM_ACTIVE  = 3'd4
  } pm_state_e;

  function automatic logic f_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic f_rise(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

  // Which events count as a wake depends on the mode; faults veto all of them.
  function automatic logic f_wake(input pm_state_e st, input logic btn_fall,
                                  input logic ac_fall, input logic en_rise,
                                  input logic en_lvl, input logic supply_ok,
                                  input logic acdet_n, input logic fault);
    logic w;
    case (st)
      PM_OFF:     w = btn_fall | ac_fall | en_rise | (supply_ok & ~acdet_n);
      PM_PRE_OFF: w = btn_fall | ac_fall | en_rise;
      PM_SUSPEND: w = btn_fall | ac_fall | en_lvl;
      default:    w = 1'b0;
    endcase
    return w & ~fault;
  endfunction

endpackage

// File: rtl/pm_edge_det.sv
module pm_edge_det (
  input  logic clk,
  input  logic btn_n,
  input  logic acdet_n,
  input  logic pwr_en,
  output logic btn_fall,
  output logic ac_fall,
  output logic en_rise
);
  import pwr_mode_pkg::*;

  // The previous values track the pins even during reset, so a line held
  // through reset does not look like an edge afterwards.
  logic btn_q, ac_q, en_q;

  always_ff @(posedge clk) begin
    btn_q <= btn_n;
    ac_q  <= acdet_n;
    en_q  <= pwr_en;
  end

  assign btn_fall = f_fall(btn_q, btn_n);
  assign ac_fall  = f_fall(ac_q, acdet_n);
  assign en_rise  = f_rise(en_q, pwr_en);

endmodule

// File: rtl/pm_grace_timer.sv
module pm_grace_timer #(
  parameter int LIMIT_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LIMIT_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run)            cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= LIMIT);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT); // R7
  AST_EXPIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(tick) && $past(run)); // R12

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wake,
  input  logic      en_lvl,
  input  logic      btn_n,
  input  logic      acdet_n,
  input  logic      fault,
  input  logic      expired,
  output pm_state_e state,
  output logic      seq_start,
  output logic      seq_stop
);

  pm_state_e nxt;
  logic      nxt_start, nxt_stop;
  logic      released;

  assign released = btn_n & acdet_n;

  always_comb begin
    nxt       = state;
    nxt_start = 1'b0;
    nxt_stop  = 1'b0;
    case (state)
      PM_OFF, PM_PRE_OFF: begin
        if (wake) begin nxt = PM_WAIT; nxt_start = 1'b1; end
      end
      PM_SUSPEND: begin
        if (fault)     begin nxt = PM_OFF;  nxt_stop  = 1'b1; end
        else if (wake) begin nxt = PM_WAIT; nxt_start = 1'b1; end
      end
      PM_WAIT: begin
        if (fault)                    begin nxt = PM_OFF; nxt_stop = 1'b1; end
        else if (en_lvl)              nxt = PM_ACTIVE;
        else if (released && expired) begin nxt = PM_OFF; nxt_stop = 1'b1; end
      end
      PM_ACTIVE: begin
        if (fault)        begin nxt = PM_OFF;     nxt_stop = 1'b1; end
        else if (!en_lvl) begin nxt = PM_SUSPEND; nxt_stop = 1'b1; end
      end
      default: nxt = PM_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PM_PRE_OFF;
      seq_start <= 1'b0;
      seq_stop  <= 1'b0;
    end else begin
      state     <= nxt;
      seq_start <= nxt_start;
      seq_stop  <= nxt_stop;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_start && seq_stop)); // R11
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !seq_start); // R11
  AST_START_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> state == PM_WAIT); // R2
  AST_STOP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    seq_stop |-> (state == PM_OFF || state == PM_SUSPEND)); // R10
  AST_ACTIVE_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_ACTIVE && $past(state) != PM_ACTIVE) |-> $past(state) == PM_WAIT); // R8
  AST_FAULT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && (state == PM_SUSPEND || state == PM_WAIT || state == PM_ACTIVE))
      |=> state == PM_OFF); // R10
  AST_NO_WAKE_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && (state == PM_OFF || state == PM_PRE_OFF)) |=> !seq_start); // R5
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_ACTIVE && en_lvl && !fault) |=> state == PM_ACTIVE); // R9

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int LIMIT_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       btn_n,
  input  logic       acdet_n,
  input  logic       pwr_en,
  input  logic       supply_ok,
  input  logic       uv_fault,
  input  logic       ot_fault,
  output logic       seq_start,
  output logic       seq_stop,
  output logic [2:0] mode
);
  import pwr_mode_pkg::*;

  logic      btn_fall, ac_fall, en_rise;
  logic      fault, wake, expired, in_wait;
  pm_state_e state;

  assign fault = uv_fault | ot_fault;

  pm_edge_det u_edge (
    .clk(clk), .btn_n(btn_n), .acdet_n(acdet_n), .pwr_en(pwr_en),
    .btn_fall(btn_fall), .ac_fall(ac_fall), .en_rise(en_rise)
  );

  assign wake = f_wake(state, btn_fall, ac_fall, en_rise, pwr_en,
                       supply_ok, acdet_n, fault);
  assign in_wait = (state == PM_WAIT);

  pm_grace_timer #(.LIMIT_TICKS(LIMIT_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_wait), .tick(tick), .expired(expired)
  );

  pm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wake(wake), .en_lvl(pwr_en),
    .btn_n(btn_n), .acdet_n(acdet_n), .fault(fault), .expired(expired),
    .state(state), .seq_start(seq_start), .seq_stop(seq_stop)
  );

  assign mode = state;

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int L = 4;
  localparam logic [2:0] M_OFF = 3'd0, M_PRE = 3'd1, M_SUS = 3'd2,
                         M_WAIT = 3'd3, M_ACT = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, btn_n = 1'b1, acdet_n = 1'b0, pwr_en = 1'b0;
  logic supply_ok = 1'b1, uv_fault = 1'b0, ot_fault = 1'b0;
  logic seq_start, seq_stop;
  logic [2:0] mode;

  // shadow values applied at the next drive
  logic n_tick = 1'b0, n_btn = 1'b1, n_ac = 1'b0, n_en = 1'b0;
  logic n_sup = 1'b1, n_uv = 1'b0, n_ot = 1'b0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [2:0] q_m[$];
  logic       q_s[$];
  logic       q_p[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.LIMIT_TICKS(L)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n), .acdet_n(acdet_n),
    .pwr_en(pwr_en), .supply_ok(supply_ok), .uv_fault(uv_fault),
    .ot_fault(ot_fault), .seq_start(seq_start), .seq_stop(seq_stop), .mode(mode)
  );

  task automatic compare(input logic [2:0] m, input logic s, input logic p,
                         input string tag);
    checks++;
    if (mode !== m || seq_start !== s || seq_stop !== p) begin
      errors++;
      $display("FAIL %s: mode/start/stop actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, mode, seq_start, seq_stop, m, s, p);
    end
  endtask

  // driver: apply inputs at a falling edge, expect the result of the next rising edge
  task automatic go(input logic [2:0] m, input logic s, input logic p, input string tag);
    @(negedge clk);
    tick = n_tick; btn_n = n_btn; acdet_n = n_ac; pwr_en = n_en;
    supply_ok = n_sup; uv_fault = n_uv; ot_fault = n_ot;
    q_m.push_back(m); q_s.push_back(s); q_p.push_back(p); q_tag.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_m.size() > 0) begin
        logic [2:0] m; logic s; logic p; string t;
        m = q_m.pop_front(); s = q_s.pop_front(); p = q_p.pop_front(); t = q_tag.pop_front();
        compare(m, s, p, t);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare(M_PRE, 1'b0, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    // pre-off: supply with AC-detect held low is no wake
    go(M_PRE, 0, 0, "R3 level no wake");
    n_ac = 1'b1; go(M_PRE, 0, 0, "R3 AC rise no wake");
    n_uv = 1'b1; n_btn = 1'b0; go(M_PRE, 0, 0, "R5 button during fault");
    n_uv = 1'b0; go(M_PRE, 0, 0, "R5 lost edge");
    n_btn = 1'b1; go(M_PRE, 0, 0, "R3 idle");
    n_en = 1'b1; go(M_WAIT, 1, 0, "R3 enable rise wakes");
    go(M_ACT, 0, 0, "R8 enable in wait");
    n_ac = 1'b0; go(M_ACT, 0, 0, "R9 AC ignored");
    n_btn = 1'b0; go(M_ACT, 0, 0, "R9 button ignored");
    n_btn = 1'b1; n_ac = 1'b1; go(M_ACT, 0, 0, "R9 hold");
    n_en = 1'b0; go(M_SUS, 0, 1, "R9 enable drop");
    go(M_SUS, 0, 0, "R11 single stop pulse");
    n_en = 1'b1; n_ot = 1'b1; go(M_OFF, 0, 1, "R10 fault beats suspend wake");
    n_ot = 1'b0; go(M_OFF, 0, 0, "R2 enable level no edge");
    n_en = 1'b0; go(M_OFF, 0, 0, "R2 idle");
    n_en = 1'b1; go(M_WAIT, 1, 0, "R2 enable rise wakes");
    go(M_ACT, 0, 0, "R8 to active");
    n_en = 1'b0; go(M_SUS, 0, 1, "R9 to suspend");
    n_en = 1'b1; go(M_WAIT, 1, 0, "R4 enable level wakes");
    go(M_ACT, 0, 0, "R8 to active");
    n_en = 1'b0; go(M_SUS, 0, 1, "R9 to suspend");
    n_btn = 1'b0; go(M_WAIT, 1, 0, "R4 button wakes suspend");
    n_tick = 1'b1;
    for (int i = 0; i < L + 2; i++) go(M_WAIT, 0, 0, "R6 hold while button low");
    n_btn = 1'b1; go(M_OFF, 0, 1, "R7 release after expiry");
    // tick in off is not counted; new entry restarts the window
    go(M_OFF, 0, 0, "R12 ticks in off");
    n_ac = 1'b0; go(M_WAIT, 1, 0, "R2 AC fall wakes");
    n_ac = 1'b1; n_tick = 1'b0;
    for (int i = 0; i < 6; i++) go(M_WAIT, 0, 0, "R12 no ticks no expiry");
    n_tick = 1'b1;
    for (int i = 0; i < L; i++) go(M_WAIT, 0, 0, "R7 window running");
    go(M_OFF, 0, 1, "R7 timeout to off");
    // supply level wake, fault blocking
    n_ac = 1'b0; go(M_WAIT, 1, 0, "R2 AC fall wakes");
    n_uv = 1'b1; go(M_OFF, 0, 1, "R10 fault in wait");
    go(M_OFF, 0, 0, "R5 level blocked by fault");
    n_uv = 1'b0; go(M_WAIT, 1, 0, "R2 supply with AC low wakes");
    n_en = 1'b1; go(M_ACT, 0, 0, "R8 to active");
    n_en = 1'b0; n_ot = 1'b1; go(M_OFF, 0, 1, "R10 fault beats enable drop");
    n_ot = 1'b0; n_ac = 1'b1; n_sup = 1'b0; go(M_OFF, 0, 0, "R2 idle");
    // expiry and enable on the same edge
    n_btn = 1'b0; go(M_WAIT, 1, 0, "R2 button fall wakes");
    for (int i = 0; i < L; i++) go(M_WAIT, 0, 0, "R6 hold");
    n_btn = 1'b1; n_en = 1'b1; go(M_ACT, 0, 0, "R8 enable beats expiry");
    n_en = 1'b0; go(M_SUS, 0, 1, "R9 to suspend");
    n_uv = 1'b1; go(M_OFF, 0, 1, "R10 fault in suspend");
    n_uv = 1'b0; go(M_OFF, 0, 0, "R11 no extra pulse");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule